// File: doc/BRIEF.md
# Two-Speed Oscillator Start-Up Sequencer

This block decides which oscillator clocks the core after power-on and after every wake from sleep. When the external source is a crystal, the block lets the core start at once on the internal oscillator. In the external crystal's own clock domain, it counts edges of the crystal until the crystal can be trusted. It then moves the clock select over to the external source and raises a start-up-done flag in the same system cycle.

The terminal count crosses back to the system domain through a two-flop synchroniser. The count request crosses the other way through a two-flop synchroniser as well. A sleep request drops the count request, so a crystal that never finishes its count before the next sleep never becomes the system clock. Every wake restarts the count from zero. An external square-wave or RC source needs only a short warm-up of a few edges, and the core is held during it. An internal-oscillator mode, or a clock-select field other than the primary value, skips the count completely.

Top module: `twospeed_startup_ctrl`

## Requirements
- R1: After reset, `clk_sel_ext`, `startup_done` and `core_run` are 0, and they stay 0 until `pwrt_done` is seen high.
- R2: With `cfg_switch_en`=1, `cfg_clk_sel`=2'b00 and a crystal mode (`cfg_osc_mode` 3'b000, 3'b001 or 3'b010), `core_run` is 1 on the internal clock while counting. `clk_sel_ext` rises between 1024 and 1030 `xtal_clk` rising edges after the start event (the `pwrt_done` rise or the wake pulse).
- R3: `startup_done` rises in the same `sys_clk` cycle as `clk_sel_ext`.
- R4: With a crystal mode, `cfg_clk_sel`=2'b00 and `cfg_switch_en`=0, `core_run` stays 0 during the 1024-edge count. It becomes 1 together with `clk_sel_ext`.
- R5: With `cfg_clk_sel` other than 2'b00, `clk_sel_ext` and `startup_done` stay 0. `core_run` is 1 as soon as the sequence starts, and no count is made.
- R6: With `cfg_osc_mode` 3'b011 (external clock) or 3'b100 (RC) and `cfg_clk_sel`=2'b00, `core_run` is held at 0 during a warm-up. `clk_sel_ext` and `core_run` rise between 2 and 8 `xtal_clk` edges after the start event.
- R7: With `cfg_osc_mode` 3'b101 to 3'b111 (internal oscillator), `clk_sel_ext` and `startup_done` stay 0 and `core_run` is 1 without a count.
- R8: A `sleep_req` pulse while awake makes `core_run` 0 on the next cycle. If the count was still running, `startup_done` and `clk_sel_ext` stay 0 for the whole sleep.
- R9: A `wake_evt` pulse during sleep clears `startup_done` and `clk_sel_ext` on the next cycle. It restarts a full count from zero, whatever was counted or completed before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock from the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_clk | input | 1 | External oscillator edges |
| cfg_switch_en | input | 1 | Enables two-speed operation |
| cfg_osc_mode | input | 3 | Oscillator mode code (see R2, R6, R7) |
| cfg_clk_sel | input | 2 | Clock-select field; 2'b00 selects the primary source |
| pwrt_done | input | 1 | Power-up timer expired (level) |
| sleep_req | input | 1 | One-cycle pulse: enter sleep |
| wake_evt | input | 1 | One-cycle pulse: wake from sleep |
| clk_sel_ext | output | 1 | 1 = system clock taken from the external source |
| startup_done | output | 1 | External source stable and in use |
| core_run | output | 1 | Core may execute |

## Verification
The checker assumes that the configuration inputs change only while reset is held. It also assumes that `pwrt_done` rises only some cycles after reset is released, and that `sleep_req` and `wake_evt` are single-cycle pulses that never arrive together. It further assumes that the external oscillator keeps toggling while the block is asleep, so that the aborted count can be cleared. The bench applies each configuration under reset and waits about twenty system cycles before raising `pwrt_done`. It drives each pulse for one cycle only and leaves `xtal_clk` free-running throughout.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_ARM   = 3'd1,
    ST_COUNT = 3'd2,
    ST_RUN   = 3'd3,
    ST_SLEEP = 3'd4
  } seq_state_t;

  localparam logic [2:0] MODE_LP = 3'b000;
  localparam logic [2:0] MODE_XT = 3'b001;
  localparam logic [2:0] MODE_HS = 3'b010;
  localparam logic [2:0] MODE_EC = 3'b011;
  localparam logic [2:0] MODE_RC = 3'b100;

  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode == MODE_LP) || (mode == MODE_XT) || (mode == MODE_HS);
  endfunction

  function automatic logic is_warm_only(input logic [2:0] mode);
    return (mode == MODE_EC) || (mode == MODE_RC);
  endfunction

endpackage

// File: rtl/ost_rst_sync.sv
module ost_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ost_bit_sync.sv
module ost_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int OST_CYCLES  = 1024,
  parameter int WARM_CYCLES = 2
) (
  input  logic xclk,
  input  logic xrst_n,
  input  logic run_i,
  input  logic warm_only_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(OST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
  logic             hit_q, hit_d, cnt_en;

  always_comb begin
    limit   = warm_only_i ? CNT_W'(WARM_CYCLES) : CNT_W'(OST_CYCLES);
    cnt_inc = cnt_q + 1'b1;
    cnt_en  = run_i && !hit_q;
    cnt_d   = cnt_q;
    hit_d   = hit_q;
    if (!run_i) begin
      cnt_d = '0;
      hit_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_inc;
      hit_d = (cnt_inc == limit);
    end
  end

  always_ff @(posedge xclk or negedge xrst_n) begin
    if (!xrst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/osc_seq_fsm.sv
module osc_seq_fsm
  import osc_startup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_switch_en,
  input  logic [2:0] cfg_osc_mode,
  input  logic [1:0] cfg_clk_sel,
  input  logic       pwrt_done,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       hit_s,
  output logic       run_o,
  output logic       sel_o,
  output logic       done_o,
  output logic       core_run_o
);
  seq_state_t state_q, state_d;
  logic       run_q, run_d;
  logic       sel_q, sel_d;
  logic       done_q, done_d;
  logic       ext_path, two_speed, hold_core;

  always_comb begin
    ext_path  = (cfg_clk_sel == 2'b00) &&
                (is_crystal(cfg_osc_mode) || is_warm_only(cfg_osc_mode));
    two_speed = (cfg_clk_sel == 2'b00) && cfg_switch_en && is_crystal(cfg_osc_mode);
    hold_core = ext_path && !two_speed;
  end

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    done_d  = done_q;
    unique case (state_q)
      ST_PWRUP: if (pwrt_done) state_d = ST_ARM;
      ST_ARM: begin
        if (sleep_req)      state_d = ST_SLEEP;
        else if (!ext_path) state_d = ST_RUN;
        else if (!hit_s)    state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (sleep_req) state_d = ST_SLEEP;
        else if (hit_s) begin
          state_d = ST_RUN;
          sel_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      ST_RUN: if (sleep_req) state_d = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_evt) begin
          state_d = ST_ARM;
          sel_d   = 1'b0;
          done_d  = 1'b0;
        end
      end
      default: state_d = ST_PWRUP;
    endcase
    run_d = (state_d == ST_COUNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      run_q   <= 1'b0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      sel_q   <= sel_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ARM, ST_COUNT: core_run_o = !hold_core;
      ST_RUN:           core_run_o = 1'b1;
      default:          core_run_o = 1'b0;
    endcase
  end

  assign run_o  = run_q;
  assign sel_o  = sel_q;
  assign done_o = done_q;
endmodule

// File: rtl/twospeed_startup_ctrl.sv
module twospeed_startup_ctrl
  import osc_startup_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int WARM_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       sys_clk,
  input  logic       rst_n,
  input  logic       xtal_clk,
  input  logic       cfg_switch_en,
  input  logic [2:0] cfg_osc_mode,
  input  logic [1:0] cfg_clk_sel,
  input  logic       pwrt_done,
  input  logic       sleep_req,
  input  logic       wake_evt,
  output logic       clk_sel_ext,
  output logic       startup_done,
  output logic       core_run
);
  logic sys_rst_n, x_rst_n;
  logic run_sys, run_x, hit_x, hit_sys;

  ost_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk(sys_clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  ost_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_x (
    .clk(xtal_clk), .arst_n(rst_n), .srst_n(x_rst_n));

  ost_bit_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(xtal_clk), .rst_n(x_rst_n), .d(run_sys), .q(run_x));

  ost_counter #(.OST_CYCLES(OST_CYCLES), .WARM_CYCLES(WARM_CYCLES)) u_cnt (
    .xclk(xtal_clk), .xrst_n(x_rst_n), .run_i(run_x),
    .warm_only_i(is_warm_only(cfg_osc_mode)), .hit_o(hit_x));

  ost_bit_sync #(.STAGES(SYNC_STAGES)) u_hit_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(hit_x), .q(hit_sys));

  osc_seq_fsm u_fsm (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .cfg_switch_en(cfg_switch_en), .cfg_osc_mode(cfg_osc_mode),
    .cfg_clk_sel(cfg_clk_sel), .pwrt_done(pwrt_done),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .hit_s(hit_sys),
    .run_o(run_sys), .sel_o(clk_sel_ext), .done_o(startup_done),
    .core_run_o(core_run));
endmodule

// File: rtl/osc_startup_chk.sv
module osc_startup_chk
  import osc_startup_pkg::*;
(
  input logic       sys_clk,
  input logic       rst_n,
  input logic       cfg_switch_en,
  input logic [2:0] cfg_osc_mode,
  input logic [1:0] cfg_clk_sel,
  input logic       pwrt_done,
  input logic       sleep_req,
  input logic       wake_evt,
  input logic       clk_sel_ext,
  input logic       startup_done,
  input logic       core_run
);
  logic pwrt_seen_q, asleep_q;
  logic awake, two_speed_cfg, held_cfg, int_mode;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrt_seen_q <= 1'b0;
      asleep_q    <= 1'b0;
    end else begin
      if (pwrt_done) pwrt_seen_q <= 1'b1;
      if (asleep_q) begin
        if (wake_evt) asleep_q <= 1'b0;
      end else if (pwrt_seen_q && sleep_req) begin
        asleep_q <= 1'b1;
      end
    end
  end

  always_comb begin
    awake         = pwrt_seen_q && !asleep_q;
    two_speed_cfg = (cfg_clk_sel == 2'b00) && cfg_switch_en && is_crystal(cfg_osc_mode);
    held_cfg      = (cfg_clk_sel == 2'b00) &&
                    ((is_crystal(cfg_osc_mode) && !cfg_switch_en) || is_warm_only(cfg_osc_mode));
    int_mode      = !is_crystal(cfg_osc_mode) && !is_warm_only(cfg_osc_mode);
  end

  AST_HOLD_BEFORE_PWRT: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !pwrt_seen_q |-> (!core_run && !clk_sel_ext && !startup_done)); // R1
  AST_TWO_SPEED_RUNS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (awake && two_speed_cfg) |-> core_run); // R2
  AST_FLAG_WITH_SELECT: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(clk_sel_ext) |-> $rose(startup_done)); // R3
  AST_HELD_UNTIL_EXT: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (held_cfg && !clk_sel_ext) |-> !core_run); // R4
  AST_SEL_FIELD_OVERRIDE: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (cfg_clk_sel != 2'b00) |-> (!clk_sel_ext && !startup_done)); // R5
  AST_INTERNAL_MODE: assert property (@(posedge sys_clk) disable iff (!rst_n)
    int_mode |-> (!clk_sel_ext && !startup_done)); // R7
  AST_SLEEP_HALTS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    asleep_q |-> !core_run); // R8
  AST_WAKE_CLEARS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (asleep_q && wake_evt) |=> (!startup_done && !clk_sel_ext)); // R9
endmodule

bind twospeed_startup_ctrl osc_startup_chk u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .cfg_switch_en(cfg_switch_en),
  .cfg_osc_mode(cfg_osc_mode), .cfg_clk_sel(cfg_clk_sel),
  .pwrt_done(pwrt_done), .sleep_req(sleep_req), .wake_evt(wake_evt),
  .clk_sel_ext(clk_sel_ext), .startup_done(startup_done), .core_run(core_run));

// File: tb/sim_twospeed_startup_ctrl.sv
`timescale 1ns/1ps
module sim_twospeed_startup_ctrl;
  logic       sys_clk = 1'b0;
  logic       xtal_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_switch_en = 1'b0;
  logic [2:0] cfg_osc_mode = 3'b000;
  logic [1:0] cfg_clk_sel = 2'b00;
  logic       pwrt_done = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic       clk_sel_ext, startup_done, core_run;

  int checks = 0;
  int failures = 0;
  int xedge = 0;

  always #2.5 sys_clk = ~sys_clk;
  always #15  xtal_clk = ~xtal_clk;
  always @(posedge xtal_clk) xedge <= xedge + 1;

  twospeed_startup_ctrl u0 (
    .sys_clk(sys_clk), .rst_n(rst_n), .xtal_clk(xtal_clk),
    .cfg_switch_en(cfg_switch_en), .cfg_osc_mode(cfg_osc_mode),
    .cfg_clk_sel(cfg_clk_sel), .pwrt_done(pwrt_done),
    .sleep_req(sleep_req), .wake_evt(wake_evt),
    .clk_sel_ext(clk_sel_ext), .startup_done(startup_done), .core_run(core_run));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input int sel, input int done, input int run);
    chk(clk_sel_ext == sel[0], {req, " clk_sel_ext"}, clk_sel_ext, sel);
    chk(startup_done == done[0], {req, " startup_done"}, startup_done, done);
    chk(core_run == run[0], {req, " core_run"}, core_run, run);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge sys_clk);
  endtask

  task automatic xcycles(input int n);
    int s;
    s = xedge;
    while (xedge - s < n) @(negedge sys_clk);
  endtask

  // Applies config under reset, checks R1, then starts; returns start edge index.
  task automatic start_up(input bit en, input logic [2:0] mode, input logic [1:0] sel,
                          output int t0);
    @(negedge sys_clk);
    rst_n = 1'b0; pwrt_done = 1'b0;
    cfg_switch_en = en; cfg_osc_mode = mode; cfg_clk_sel = sel;
    cycles(4);
    rst_n = 1'b1;
    cycles(20);
    outs("R1 before pwrt_done", 0, 0, 0);
    t0 = xedge;
    pwrt_done = 1'b1;
    cycles(1);
  endtask

  task automatic wait_ext(input int t0, input int lo, input int hi, input string req);
    int n;
    while (!clk_sel_ext && (xedge - t0) <= hi + 4) @(negedge sys_clk);
    n = xedge - t0;
    chk(clk_sel_ext && n >= lo && n <= hi, {req, " handover edge window"}, n, lo);
    chk(startup_done == 1'b1, "R3 flag with select", startup_done, 1);
    chk(core_run == 1'b1, {req, " core runs on external"}, core_run, 1);
  endtask

  task automatic pulse_sleep;
    sleep_req = 1'b1; @(negedge sys_clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake(output int t0);
    t0 = xedge;
    wake_evt = 1'b1; @(negedge sys_clk); wake_evt = 1'b0;
  endtask

  task automatic t_two_speed;
    int t0;
    start_up(1'b1, 3'b001, 2'b00, t0);
    xcycles(500);
    outs("R2 counting on internal", 0, 0, 1);
    wait_ext(t0, 1024, 1030, "R2");
  endtask

  task automatic t_no_switch;
    int t0;
    start_up(1'b0, 3'b010, 2'b00, t0);
    xcycles(1000);
    outs("R4 core held during count", 0, 0, 0);
    wait_ext(t0, 1024, 1030, "R4");
  endtask

  task automatic t_sel_field;
    int t0;
    start_up(1'b1, 3'b000, 2'b10, t0);
    cycles(2);
    outs("R5 internal without count", 0, 0, 1);
    xcycles(1100);
    outs("R5 never external", 0, 0, 1);
  endtask

  task automatic t_warm(input logic [2:0] mode);
    int t0;
    start_up(1'b1, mode, 2'b00, t0);
    cycles(2);
    outs("R6 held in warm-up", 0, 0, 0);
    wait_ext(t0, 2, 8, "R6");
  endtask

  task automatic t_int_mode;
    int t0;
    start_up(1'b1, 3'b110, 2'b00, t0);
    cycles(2);
    outs("R7 internal mode runs", 0, 0, 1);
    xcycles(1100);
    outs("R7 stays internal", 0, 0, 1);
  endtask

  task automatic t_sleep_abort;
    int t0;
    start_up(1'b1, 3'b000, 2'b00, t0);
    xcycles(300);
    pulse_sleep();
    outs("R8 sleep mid-count", 0, 0, 0);
    xcycles(1200);
    outs("R8 count aborted", 0, 0, 0);
    pulse_wake(t0);
    outs("R9 wake after abort", 0, 0, 1);
    wait_ext(t0, 1024, 1030, "R9 full count after abort");
  endtask

  task automatic t_wake_restart;
    int t0;
    start_up(1'b1, 3'b010, 2'b00, t0);
    wait_ext(t0, 1024, 1030, "R2");
    pulse_sleep();
    outs("R8 sleep after handover", 1, 1, 0);
    xcycles(20);
    pulse_wake(t0);
    outs("R9 wake clears select and flag", 0, 0, 1);
    wait_ext(t0, 1024, 1030, "R9 restart from zero");
  endtask

  initial begin
    #900us;
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_two_speed();
    t_no_switch();
    t_sel_field();
    t_warm(3'b011);
    t_warm(3'b100);
    t_int_mode();
    t_sleep_abort();
    t_wake_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule